// File: doc/BRIEF.md
# Control-Word Asynchronous Serial Adapter

This block is a character-at-a-time asynchronous serial port. Its whole configuration sits in one control byte. That byte sets the bit-rate divisor, one of eight character formats, the request-to-send and transmit-interrupt mode, a line-break mode and the receive interrupt enable. The host side has one transmit holding byte and one receive buffer byte. Every condition it can report is packed into a single status byte.

A host writes the control byte, loads characters with a write strobe and collects received characters with a read strobe. The host then watches the status byte or the active-low interrupt line. The serial side has a receive line, active-low carrier-detect and clear-to-send inputs, a transmit line, an active-low request-to-send output and an active-low interrupt output.

Top module: `ctlword_uart`

## Requirements
- R1: Control bits 1:0 equal to 11 is a master reset, and hardware reset loads the control byte with 8'h03. While it holds, the receive-full, overrun, framing, parity and carrier-loss flags are cleared, the transmit holding byte reads empty, transmit writes are ignored and txd stays high.
- R2: Control bits 4:2 pick the frame. Codes 000/001/010/011 are 7 data bits with even/odd/even/odd parity and 2/2/1/1 stop bits. Codes 100/101/110/111 are 8 data bits with none/none/even/odd parity and 2/1/1/1 stop bits. A transmitted frame is a 0 start bit, then the data LSB first, then the parity bit if there is one, then the 1-level stop bits.
- R3: Control bits 1:0 set each bit time: 00 is one clock, 01 is DIV_MID clocks (16) and 10 is DIV_HI clocks (64).
- R4: A start is a high-to-low transition on rxd. In the 16 and 64 modes the line is checked again half a bit later, and a low pulse shorter than that is ignored. Each data, parity and stop bit is then sampled once, one full bit time after the previous sample.
- R5: When the first stop bit is sampled, the character goes to rx_data (bit 7 is 0 for 7-bit formats) and status bit 0 (receive full) is set. Status bit 4 is set if that stop bit was 0. Status bit 6 is set if the parity bit disagrees with the selected parity.
- R6: If a character completes while status bit 0 is still set and no read occurs in that cycle, status bit 5 (overrun) is set, the new character is dropped and rx_data keeps the old one.
- R7: A read strobe clears status bits 0, 4, 5 and 6 and the carrier-loss latch.
- R8: Control bits 6:5 set rts_n to 1 only for code 10 and to 0 otherwise. Code 01 enables the transmit interrupt. Code 11 holds txd at 0 (break) and starts no character.
- R9: Status bit 3 follows cts_n. While cts_n is 1, status bit 1 (transmit empty) reads 0 and no new character starts. A loaded character starts once cts_n returns to 0.
- R10: Status bit 7, and irq_n low, mean at least one of three conditions holds: receive full with control bit 7 set, transmit empty with control bits 6:5 equal to 01, or a latched carrier loss with control bit 7 set.
- R11: Status bit 2 follows dcd_n. A 0-to-1 change of dcd_n while control bit 7 is set latches a carrier loss that raises the interrupt until a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the bit-rate reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control byte |
| tx_we | input | 1 | Write strobe for the transmit holding byte |
| rx_re | input | 1 | Read strobe for the receive buffer |
| wdata | input | 8 | Write data for both write strobes |
| rx_data | output | 8 | Receive buffer contents |
| status | output | 8 | Packed status byte |
| rxd | input | 1 | Serial receive line |
| dcd_n | input | 1 | Carrier detect, active low |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial transmit line |
| rts_n | output | 1 | Request to send, active low |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
All eight frame formats are sent at the 16-clock rate with data values that differ per format. A wrong data width, parity sense or stop count would show up there as a bit mismatch on the line. One frame at the 64-clock rate and one looped back from txd to rxd at the one-clock rate separate the three divisor codes. The looped frame also checks that the receiver can sample without a half-bit check. Received frames with good parity, bad parity and a zero stop bit separate the error flags. A short low glitch followed by a real frame shows that a false start is rejected and that the receiver comes back idle. Back-to-back frames without a read separate overrun from a plain overwrite.

// File: rtl/cwu_pkg.sv
package cwu_pkg;

    typedef struct packed {
        logic data8;
        logic par_en;
        logic par_odd;
        logic stop2;
    } fmt_t;

    typedef struct packed {
        logic [11:0] bits;
        logic [3:0]  len;
    } frame_t;

    function automatic fmt_t decode_fmt(input logic [2:0] code);
        fmt_t f;
        f.data8   = code[2];
        f.par_en  = !(code[2] && !code[1]);
        f.par_odd = code[0];
        f.stop2   = !code[1] && !(code[2] && code[0]);
        return f;
    endfunction

    function automatic frame_t build_frame(input logic [7:0] d, input fmt_t f);
        frame_t r;
        int     nd;
        logic   p;
        nd = f.data8 ? 8 : 7;
        p  = (f.data8 ? ^d : ^d[6:0]) ^ f.par_odd;
        r.bits    = '1;
        r.bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < nd) r.bits[1 + i] = d[i];
        end
        if (f.par_en) r.bits[1 + nd] = p;
        r.len = 4'(2 + nd + (f.par_en ? 1 : 0) + (f.stop2 ? 1 : 0));
        return r;
    endfunction

endpackage

// File: rtl/cwu_tx.sv
module cwu_tx
    import cwu_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic [CW-1:0] div,
    input  fmt_t          fmt,
    input  logic          start,
    input  logic [7:0]    data,
    output logic          busy,
    output logic          line
);

    typedef struct packed {
        logic          busy;
        logic [11:0]   sh;
        logic [3:0]    left;
        logic [CW-1:0] cnt;
    } tx_s;

    tx_s    tx_q, tx_d;
    frame_t fr;

    always_comb begin
        tx_d = tx_q;
        fr   = build_frame(data, fmt);
        if (hold) begin
            tx_d.busy = 1'b0;
            tx_d.sh   = '1;
        end else if (!tx_q.busy) begin
            if (start) begin
                tx_d.busy = 1'b1;
                tx_d.sh   = fr.bits;
                tx_d.left = fr.len;
                tx_d.cnt  = CW'(1);
            end
        end else if (tx_q.cnt == div) begin
            tx_d.cnt = CW'(1);
            if (tx_q.left == 4'd1) begin
                tx_d.busy = 1'b0;
            end else begin
                tx_d.sh   = {1'b1, tx_q.sh[11:1]};
                tx_d.left = tx_q.left - 4'd1;
            end
        end else begin
            tx_d.cnt = tx_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q.busy <= 1'b0;
            tx_q.sh   <= '1;
            tx_q.left <= '0;
            tx_q.cnt  <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign busy = tx_q.busy;
    assign line = tx_q.busy ? tx_q.sh[0] : 1'b1;

endmodule

// File: rtl/cwu_rx.sv
module cwu_rx #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic [CW-1:0] div,
    input  logic          data8,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          rxd,
    output logic          done,
    output logic [7:0]    data,
    output logic          fe,
    output logic          pe
);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

    typedef struct packed {
        rx_st_e        st;
        logic          prev;
        logic [CW-1:0] cnt;
        logic [3:0]    idx;
        logic [9:0]    rec;
        logic          done;
        logic [7:0]    data;
        logic          fe;
        logic          pe;
    } rx_s;

    rx_s           rx_q, rx_d;
    logic [CW-1:0] half;
    logic [3:0]    par_idx;
    logic [3:0]    last_idx;
    logic [7:0]    word;
    logic          want_par;

    always_comb begin
        half     = div >> 1;
        par_idx  = data8 ? 4'd8 : 4'd7;
        last_idx = par_idx + {3'b000, par_en};
        rx_d      = rx_q;
        rx_d.done = 1'b0;
        rx_d.prev = rxd;
        word      = '0;
        want_par  = 1'b0;
        if (hold) begin
            rx_d.st  = RX_IDLE;
            rx_d.idx = '0;
        end else begin
            case (rx_q.st)
                RX_IDLE: begin
                    if (rx_q.prev && !rxd) begin
                        rx_d.cnt = CW'(1);
                        rx_d.idx = '0;
                        rx_d.st  = (half == '0) ? RX_BITS : RX_START;
                    end
                end
                RX_START: begin
                    if (rx_q.cnt == half) begin
                        rx_d.st  = rxd ? RX_IDLE : RX_BITS;
                        rx_d.cnt = CW'(1);
                    end else begin
                        rx_d.cnt = rx_q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (rx_q.cnt == div) begin
                        rx_d.cnt          = CW'(1);
                        rx_d.rec[rx_q.idx] = rxd;
                        if (rx_q.idx == last_idx) begin
                            word      = data8 ? rx_d.rec[7:0] : {1'b0, rx_d.rec[6:0]};
                            want_par  = (^word) ^ par_odd;
                            rx_d.st   = RX_IDLE;
                            rx_d.done = 1'b1;
                            rx_d.data = word;
                            rx_d.fe   = !rx_d.rec[last_idx];
                            rx_d.pe   = par_en && (rx_d.rec[par_idx] != want_par);
                        end else begin
                            rx_d.idx = rx_q.idx + 4'd1;
                        end
                    end else begin
                        rx_d.cnt = rx_q.cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q.st   <= RX_IDLE;
            rx_q.prev <= 1'b0;
            rx_q.cnt  <= '0;
            rx_q.idx  <= '0;
            rx_q.rec  <= '0;
            rx_q.done <= 1'b0;
            rx_q.data <= '0;
            rx_q.fe   <= 1'b0;
            rx_q.pe   <= 1'b0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign done = rx_q.done;
    assign data = rx_q.data;
    assign fe   = rx_q.fe;
    assign pe   = rx_q.pe;

endmodule

// File: rtl/ctlword_uart.sv
module ctlword_uart
    import cwu_pkg::*;
#(
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic       tx_we,
    input  logic       rx_re,
    input  logic [7:0] wdata,
    output logic [7:0] rx_data,
    output logic [7:0] status,
    input  logic       rxd,
    input  logic       dcd_n,
    input  logic       cts_n,
    output logic       txd,
    output logic       rts_n,
    output logic       irq_n
);

    localparam int CW = $clog2(DIV_HI + 1);

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] tdata;
        logic       hfull;
        logic [7:0] rbuf;
        logic       rdrf;
        logic       ovrn;
        logic       fe;
        logic       pe;
        logic       dlost;
        logic       rxd_s;
        logic       dcd_s;
        logic       cts_s;
    } top_s;

    top_s          r_q, r_d;
    fmt_t          fmt;
    logic [CW-1:0] div;
    logic          mr;
    logic          rx_ien;
    logic          brk;
    logic          tdre;
    logic          irq;
    logic          tx_start;
    logic          tx_busy;
    logic          tx_line;
    logic          rx_done;
    logic [7:0]    rx_byte;
    logic          rx_fe;
    logic          rx_pe;

    always_comb begin
        fmt    = decode_fmt(r_q.ctrl[4:2]);
        mr     = (r_q.ctrl[1:0] == 2'b11);
        rx_ien = r_q.ctrl[7];
        brk    = (r_q.ctrl[6:5] == 2'b11) && !mr;
        case (r_q.ctrl[1:0])
            2'b00:   div = CW'(1);
            2'b01:   div = CW'(DIV_MID);
            default: div = CW'(DIV_HI);
        endcase
        tdre     = !r_q.hfull && !r_q.cts_s;
        irq      = (r_q.rdrf && rx_ien) ||
                   (tdre && r_q.ctrl[6:5] == 2'b01) ||
                   (r_q.dlost && rx_ien);
        tx_start = r_q.hfull && !tx_busy && !r_q.cts_s && !mr && !brk;
    end

    always_comb begin
        r_d       = r_q;
        r_d.rxd_s = rxd;
        r_d.dcd_s = dcd_n;
        r_d.cts_s = cts_n;
        if (ctrl_we) r_d.ctrl = wdata;
        if (mr) begin
            r_d.hfull = 1'b0;
            r_d.rdrf  = 1'b0;
            r_d.ovrn  = 1'b0;
            r_d.fe    = 1'b0;
            r_d.pe    = 1'b0;
            r_d.dlost = 1'b0;
        end else begin
            if (tx_start) r_d.hfull = 1'b0;
            if (tx_we) begin
                r_d.hfull = 1'b1;
                r_d.tdata = wdata;
            end
            if (rx_re) begin
                r_d.rdrf  = 1'b0;
                r_d.ovrn  = 1'b0;
                r_d.fe    = 1'b0;
                r_d.pe    = 1'b0;
                r_d.dlost = 1'b0;
            end
            if (rx_done) begin
                if (r_q.rdrf && !rx_re) begin
                    r_d.ovrn = 1'b1;
                end else begin
                    r_d.rbuf = rx_byte;
                    r_d.rdrf = 1'b1;
                    r_d.fe   = rx_fe;
                    r_d.pe   = rx_pe;
                end
            end
            if (!r_q.dcd_s && dcd_n && rx_ien) r_d.dlost = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl  <= 8'h03;
            r_q.tdata <= '0;
            r_q.hfull <= 1'b0;
            r_q.rbuf  <= '0;
            r_q.rdrf  <= 1'b0;
            r_q.ovrn  <= 1'b0;
            r_q.fe    <= 1'b0;
            r_q.pe    <= 1'b0;
            r_q.dlost <= 1'b0;
            r_q.rxd_s <= 1'b1;
            r_q.dcd_s <= 1'b0;
            r_q.cts_s <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    cwu_tx #(.CW(CW)) tx_i (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (mr),
        .div   (div),
        .fmt   (fmt),
        .start (tx_start),
        .data  (r_q.tdata),
        .busy  (tx_busy),
        .line  (tx_line)
    );

    cwu_rx #(.CW(CW)) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (mr),
        .div     (div),
        .data8   (fmt.data8),
        .par_en  (fmt.par_en),
        .par_odd (fmt.par_odd),
        .rxd     (r_q.rxd_s),
        .done    (rx_done),
        .data    (rx_byte),
        .fe      (rx_fe),
        .pe      (rx_pe)
    );

    assign rx_data = r_q.rbuf;
    assign status  = {irq, r_q.pe, r_q.ovrn, r_q.fe, r_q.cts_s, r_q.dcd_s, tdre, r_q.rdrf};
    assign txd     = brk ? 1'b0 : tx_line;
    assign rts_n   = (r_q.ctrl[6:5] == 2'b10);
    assign irq_n   = !irq;

endmodule

// File: rtl/cwu_chk.sv
module cwu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mr,
    input logic       rx_ien,
    input logic       rdrf,
    input logic       cts_off,
    input logic [2:0] errs,
    input logic [7:0] rx_data,
    input logic       txd,
    input logic       irq_n,
    input logic       rx_re,
    input logic       rx_done,
    input logic       tx_busy
);

    assert_master_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mr && $past(mr) |-> !rdrf && errs == 3'b000 && txd);

    assert_done_sets_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !mr |=> rdrf);

    assert_overrun_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && rdrf && !rx_re && !mr |=> errs[1] && $stable(rx_data));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_re && !rx_done |=> !rdrf && errs == 3'b000);

    assert_cts_gates_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !$past(cts_off));

    assert_rx_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rdrf && rx_ien |-> !irq_n);

endmodule

bind ctlword_uart cwu_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mr      (mr),
    .rx_ien  (rx_ien),
    .rdrf    (status[0]),
    .cts_off (status[3]),
    .errs    (status[6:4]),
    .rx_data (rx_data),
    .txd     (txd),
    .irq_n   (irq_n),
    .rx_re   (rx_re),
    .rx_done (rx_done),
    .tx_busy (tx_busy)
);

// File: tb/ctlword_uart_tb_top.sv
module ctlword_uart_tb_top;

    typedef struct {
        logic [11:0] bits;
        int          len;
        int          ppos;
        int          spos;
    } tfr_t;

    typedef struct {
        logic [7:0] d;
        logic       fe;
        logic       pe;
    } rxe_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic       tx_we = 1'b0;
    logic       mon_re = 1'b0;
    logic       task_re = 1'b0;
    logic [7:0] wdata = '0;
    logic       rxd_drv = 1'b1;
    logic       loop = 1'b0;
    logic       dcd_n = 1'b0;
    logic       cts_n = 1'b0;
    logic [7:0] rx_data;
    logic [7:0] status;
    logic       txd;
    logic       rts_n;
    logic       irq_n;
    logic       rxd;
    logic       rx_re;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   ended = 0;
    int   cur_div = 1;
    logic [2:0] cur_fmt = 3'd0;
    bit   txmon_en = 0;
    bit   rxmon_en = 0;
    tfr_t txq[$];
    rxe_t rxq[$];

    always #2 clk = ~clk;

    assign rxd   = loop ? txd : rxd_drv;
    assign rx_re = mon_re | task_re;

    ctlword_uart dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_we),
        .tx_we   (tx_we),
        .rx_re   (rx_re),
        .wdata   (wdata),
        .rx_data (rx_data),
        .status  (status),
        .rxd     (rxd),
        .dcd_n   (dcd_n),
        .cts_n   (cts_n),
        .txd     (txd),
        .rts_n   (rts_n),
        .irq_n   (irq_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic tfr_t exp_frame(input logic [2:0] f, input logic [7:0] d);
        tfr_t r;
        int   nd, pm, ns, pos;
        case (f)
            3'd0: begin nd = 7; pm = 1; ns = 2; end
            3'd1: begin nd = 7; pm = 2; ns = 2; end
            3'd2: begin nd = 7; pm = 1; ns = 1; end
            3'd3: begin nd = 7; pm = 2; ns = 1; end
            3'd4: begin nd = 8; pm = 0; ns = 2; end
            3'd5: begin nd = 8; pm = 0; ns = 1; end
            3'd6: begin nd = 8; pm = 1; ns = 1; end
            default: begin nd = 8; pm = 2; ns = 1; end
        endcase
        r.bits = '1;
        r.bits[0] = 1'b0;
        pos = 1;
        for (int i = 0; i < nd; i++) begin
            r.bits[pos] = d[i];
            pos++;
        end
        r.ppos = pos;
        if (pm != 0) begin
            logic ones;
            ones = 1'b0;
            for (int i = 0; i < nd; i++) ones = ones ^ d[i];
            r.bits[pos] = (pm == 1) ? ones : ~ones;
            pos++;
        end
        r.spos = pos;
        r.len = pos + ns;
        return r;
    endfunction

    function automatic int div_of(input logic [1:0] c);
        return (c == 2'b00) ? 1 : (c == 2'b01) ? 16 : 64;
    endfunction

    task automatic wr_ctrl(input logic c7, input logic [1:0] tc, input logic [2:0] f, input logic [1:0] dv);
        @(negedge clk);
        ctrl_we = 1'b1;
        wdata = {c7, tc, f, dv};
        @(negedge clk);
        ctrl_we = 1'b0;
        cur_div = div_of(dv);
        cur_fmt = f;
    endtask

    task automatic send_tx(input logic [7:0] d);
        txq.push_back(exp_frame(cur_fmt, d));
        @(negedge clk);
        tx_we = 1'b1;
        wdata = d;
        @(negedge clk);
        tx_we = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] d, input bit badpar, input bit badstop, input bit push);
        tfr_t fr;
        rxe_t e;
        fr = exp_frame(cur_fmt, d);
        if (badpar) fr.bits[fr.ppos] = ~fr.bits[fr.ppos];
        if (badstop) fr.bits[fr.spos] = 1'b0;
        e.d  = cur_fmt[2] ? d : {1'b0, d[6:0]};
        e.fe = badstop;
        e.pe = badpar;
        if (push) rxq.push_back(e);
        for (int k = 0; k < fr.len; k++) begin
            rxd_drv = fr.bits[k];
            repeat (cur_div) @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (cur_div + 8) @(negedge clk);
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        task_re = 1'b1;
        @(negedge clk);
        task_re = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // transmit line monitor: samples each bit in its middle
    initial begin
        forever begin
            @(negedge clk);
            if (txmon_en && txd === 1'b0) begin
                tfr_t        e;
                logic [11:0] got;
                int          f;
                int          miss;
                f = cur_div;
                got = '1;
                for (int k = 0; k < 12; k++) begin
                    if (k == 0) repeat (f / 2) @(negedge clk);
                    else repeat (f) @(negedge clk);
                    got[k] = txd;
                    if (txq.size() > 0 && k + 1 >= txq[0].len) break;
                end
                if (txq.size() == 0) begin
                    chk(0, "R2 unexpected frame", 32'(got), 32'hfff);
                end else begin
                    e = txq.pop_front();
                    miss = 0;
                    for (int k = 0; k < e.len; k++) if (got[k] !== e.bits[k]) miss++;
                    chk(miss == 0, "R2/R3 tx frame", 32'(got), 32'(e.bits));
                end
                repeat (f) @(negedge clk);
            end
        end
    end

    // receive buffer monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rxmon_en && status[0] === 1'b1) begin
                rxe_t e;
                if (rxq.size() == 0) begin
                    chk(0, "R5 unexpected char", 32'(rx_data), 32'h0);
                end else begin
                    e = rxq.pop_front();
                    chk(rx_data === e.d && status[4] === e.fe && status[6] === e.pe,
                        "R4/R5 rx char {data,fe,pe}",
                        {22'b0, rx_data, status[4], status[6]}, {22'b0, e.d, e.fe, e.pe});
                end
                mon_re = 1'b1;
                @(negedge clk);
                mon_re = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all-reqs actual=running expected=finished");
        finish_run();
    end

    initial begin
        bit low_seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state is master reset, transmit empty, line idle
        chk(status === 8'h02, "R1 status after reset", 32'(status), 32'h02);
        chk(txd === 1'b1 && irq_n === 1'b1 && rts_n === 1'b0, "R1 pins after reset",
            {29'b0, txd, irq_n, rts_n}, 32'h6);
        send_tx(8'h5A);
        repeat (20) @(negedge clk);
        chk(status[1] === 1'b1 && txd === 1'b1, "R1 tx write ignored in master reset",
            {30'b0, status[1], txd}, 32'h3);
        txq.delete();

        // R2/R3: every format at the 16-clock rate
        txmon_en = 1;
        for (int f = 0; f < 8; f++) begin
            wr_ctrl(1'b0, 2'b00, 3'(f), 2'b01);
            send_tx(8'hA5 ^ 8'(f * 37));
            repeat (12 * 16 + 30) @(negedge clk);
        end
        // R3: 64-clock rate
        wr_ctrl(1'b0, 2'b00, 3'd3, 2'b10);
        send_tx(8'h6C);
        repeat (12 * 64 + 80) @(negedge clk);

        // R4/R5: receiver at the 16-clock rate
        rxmon_en = 1;
        wr_ctrl(1'b0, 2'b00, 3'd7, 2'b01);
        send_rx(8'h3C, 0, 0, 1);
        wr_ctrl(1'b0, 2'b00, 3'd2, 2'b01);
        send_rx(8'hD5, 0, 0, 1);
        send_rx(8'h21, 1, 0, 1);
        send_rx(8'h4E, 0, 1, 1);
        repeat (40) @(negedge clk);
        // R4: short glitch is not a start
        rxd_drv = 1'b0;
        repeat (5) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (300) @(negedge clk);
        chk(status[0] === 1'b0, "R4 glitch ignored", 32'(status[0]), 32'h0);
        send_rx(8'h19, 0, 0, 1);
        repeat (40) @(negedge clk);
        chk(rxq.size() == 0, "R4 all chars received", rxq.size(), 0);

        // R3: one-clock rate, looped back
        wr_ctrl(1'b0, 2'b00, 3'd5, 2'b00);
        loop = 1'b1;
        rxq.push_back('{d: 8'h96, fe: 1'b0, pe: 1'b0});
        send_tx(8'h96);
        repeat (60) @(negedge clk);
        chk(rxq.size() == 0 && txq.size() == 0, "R3 loopback at one-clock rate",
            rxq.size() + txq.size(), 0);
        loop = 1'b0;
        rxmon_en = 0;

        // R6/R7: overrun, then read clears
        wr_ctrl(1'b0, 2'b00, 3'd5, 2'b01);
        send_rx(8'h11, 0, 0, 0);
        send_rx(8'h22, 0, 0, 0);
        chk(status[0] === 1'b1 && status[5] === 1'b1 && rx_data === 8'h11, "R6 overrun keeps first",
            {23'b0, status[0], status[5], rx_data}, {23'b0, 2'b11, 8'h11});
        rd_pulse();
        @(negedge clk);
        chk(status[0] === 1'b0 && status[6:4] === 3'b000, "R7 read clears flags",
            32'(status), 32'(status & 8'h8E));

        // R8: transmit control codes
        txmon_en = 0;
        wr_ctrl(1'b0, 2'b10, 3'd5, 2'b01);
        chk(rts_n === 1'b1, "R8 rts high for code 10", 32'(rts_n), 32'h1);
        wr_ctrl(1'b0, 2'b11, 3'd5, 2'b01);
        @(negedge clk);
        chk(txd === 1'b0 && rts_n === 1'b0, "R8 break holds txd low", {30'b0, txd, rts_n}, 32'h0);
        wr_ctrl(1'b0, 2'b00, 3'd5, 2'b01);
        @(negedge clk);
        chk(txd === 1'b1 && rts_n === 1'b0, "R8 back to idle", {30'b0, txd, rts_n}, 32'h2);
        txmon_en = 1;

        // R9: clear-to-send gating
        cts_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(status[1] === 1'b0 && status[3] === 1'b1, "R9 empty masked by cts",
            {30'b0, status[1], status[3]}, 32'h1);
        send_tx(8'hC3);
        low_seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd === 1'b0) low_seen = 1;
        end
        chk(!low_seen, "R9 no start while cts inactive", 32'(low_seen), 32'h0);
        cts_n = 1'b0;
        repeat (12 * 16 + 40) @(negedge clk);
        chk(txq.size() == 0, "R9 frame sent after cts", txq.size(), 0);

        // R10: interrupt sources
        wr_ctrl(1'b0, 2'b01, 3'd5, 2'b01);
        @(negedge clk);
        chk(irq_n === 1'b0 && status[7] === 1'b1, "R10 tx empty interrupt", {30'b0, irq_n, status[7]}, 32'h1);
        wr_ctrl(1'b1, 2'b00, 3'd5, 2'b01);
        @(negedge clk);
        chk(irq_n === 1'b1, "R10 no source", 32'(irq_n), 32'h1);
        send_rx(8'h7E, 0, 0, 0);
        chk(irq_n === 1'b0 && status[7] === 1'b1, "R10 rx full interrupt", {30'b0, irq_n, status[7]}, 32'h1);
        rd_pulse();
        @(negedge clk);
        chk(irq_n === 1'b1, "R10 cleared by read", 32'(irq_n), 32'h1);

        // R11: carrier loss
        dcd_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(status[2] === 1'b1 && irq_n === 1'b0, "R11 carrier loss interrupt", {30'b0, status[2], irq_n}, 32'h2);
        rd_pulse();
        @(negedge clk);
        chk(status[2] === 1'b1 && irq_n === 1'b1, "R11 latch cleared by read", {30'b0, status[2], irq_n}, 32'h3);
        dcd_n = 1'b0;
        repeat (3) @(negedge clk);

        // R1: master reset clears pending receive state
        send_rx(8'h44, 0, 1, 0);
        chk(status[0] === 1'b1, "R1 setup char present", 32'(status[0]), 32'h1);
        wr_ctrl(1'b0, 2'b00, 3'd5, 2'b11);
        @(negedge clk);
        chk(status[0] === 1'b0 && status[6:4] === 3'b000 && txd === 1'b1, "R1 master reset clears",
            32'(status), 32'h02);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule